// File: doc/BRIEF.md
# Instruction Prefetch Front End with Deferred Fetch Faults

This block is the fetch side of a small 32-bit core whose instructions are all four bytes long. It runs ahead of execution, reading instruction words over a shared memory port and keeping up to two of them queued in front of the word that execute currently holds. Each queued word travels with a fault bit. That bit is set when the memory port rejected the read, or when the address lies in the I/O window, where code fetches are refused before they reach the bus. The fault is only reported to execute when the word itself becomes the current instruction.

When the instruction in execute writes the program counter, execute raises a redirect with the new address. The block discards its queue and the read still in flight, and begins fetching at the new address in the same cycle. This gives exactly two empty execute cycles before the target instruction appears. Any faults attached to the discarded words disappear with them. Execute may also use the memory port for data reads and writes. Those requests win the port for the cycle they are raised, are tagged as data, and may address the I/O window.

Top module: `fetch_front`

## Requirements
- R1: While reset is low and in the first two cycles after it, ex_valid is 0. The first fetch issued is a code request to address 0. In the third cycle after reset, execute holds the word at address 0.
- R2: When execute completes an instruction every cycle, a new word arrives in execute every cycle, with ex_pc rising by 4 each time.
- R3: While execute is stalled (ex_valid=1, ex_done=0), the word in execute is held. No more than two words are fetched ahead of it, so fetching stops. No word is lost or repeated when execute resumes.
- R4: A redirect (ex_redirect=1 together with ex_done=1) empties the queue and cancels the read in flight. ex_valid is 0 for exactly the next two cycles, and the cycle after that holds the target word.
- R5: Bits 1:0 of ex_target are ignored. The code request issued in the redirect cycle uses the target with those bits cleared.
- R6: A fetch answered with mem_err=1 reaches execute with ex_fault=1. ex_fault is 1 only while ex_valid is 1 and the current word carries the fault.
- R7: Faults on words that a redirect discards never show on ex_fault.
- R8: mem_code is 1 for an instruction fetch and 0 for a data access. While dat_req=1, the port carries the data access at dat_addr, and no fetch is made in that cycle.
- R9: A code fetch to an address A with (A & IO_MASK) == IO_BASE (default: bits 31:28 equal to 0xF) never drives mem_req. The word still enters the queue, with its fault bit set.
- R10: A data access into the I/O window is passed to the port unchanged.
- R11: Completion without a redirect, as for an instruction skipped by its condition, causes no flush. The next sequential word enters execute in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Memory port request |
| mem_code | output | 1 | 1 for instruction fetch, 0 for data access |
| mem_addr | output | 32 | Memory port address |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| mem_err | input | 1 | Bus fault, valid the cycle after the request |
| dat_req | input | 1 | Data access request from execute |
| dat_addr | input | 32 | Data access address |
| ex_done | input | 1 | Instruction in execute completes this cycle |
| ex_redirect | input | 1 | Completing instruction writes the program counter |
| ex_target | input | 32 | New program counter value |
| ex_valid | output | 1 | Execute holds a word |
| ex_pc | output | 32 | Address of the word in execute |
| ex_instr | output | 32 | Instruction word in execute |
| ex_fault | output | 1 | Word in execute was fetched with a fault |

## Verification
The assertions assume that execute raises ex_done and ex_redirect only while ex_valid is 1, and always raises ex_redirect together with ex_done. They also assume that the memory port answers every request in the following cycle. The bench keeps to these rules. Its memory model is a one-cycle register, and the vector table and the directed sequences drive completion and redirect only in cycles where the expected ex_valid is 1. Data requests are raised only in cycles with no redirect.

// File: rtl/fe_pkg.sv
// Shared definitions for the prefetch front end.
// Assumes fixed 32-bit addresses and 32-bit instruction words.
package fe_pkg;
    localparam int AW = 32;
    localparam int IW = 32;

    // One fetched instruction with its deferred fault tag
    typedef struct packed {
        logic [AW-1:0] pc;
        logic [IW-1:0] instr;
        logic          fault;
    } fe_word_t;
endpackage

// File: rtl/fe_io_guard.sv
// Address window compare used to refuse code fetches to I/O space.
// Assumes the window is aligned, so that BASE has no bits outside MASK.
module fe_io_guard #(
    parameter int          AW   = 32,
    parameter logic [AW-1:0] BASE = 32'hF000_0000,
    parameter logic [AW-1:0] MASK = 32'hF000_0000
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    // Window membership compare
    always_comb begin
        hit = ((addr & MASK) == (BASE & MASK));
    end
endmodule

// File: rtl/fe_word_fifo.sv
// Small queue of prefetched words with a flush that empties it at once.
// Assumes the caller never pushes when full and never pops when empty.
module fe_word_fifo
    import fe_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  fe_word_t      push_word,
    input  logic          pop,
    output fe_word_t      head,
    output logic          empty,
    output logic [CW-1:0] count
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    fe_word_t      slot [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Step a pointer around the ring
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    // Head and empty flag
    always_comb begin
        head  = slot[rd_ptr];
        empty = (count == '0);
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    // Slot storage, one write port per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (push && !flush && (wr_ptr == PW'(g))) begin
                slot[g] <= push_word;
            end
        end
    end
endmodule

// File: rtl/fe_exec_stage.sv
// Execute-stage holding register: takes the queue head when execute is
// free, holds it while execute is busy, and empties on a redirect.
// Assumes done and flush are only raised while a word is held.
module fe_exec_stage
    import fe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     done,
    input  logic     q_empty,
    input  fe_word_t q_head,
    output logic     pop,
    output logic     valid,
    output fe_word_t word
);
    logic take;

    // Decide whether the stage accepts a new word this cycle
    always_comb begin
        take = (!valid || done) && !flush;
        pop  = take && !q_empty;
    end

    // Stage register update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid <= 1'b0;
            word  <= '0;
        end else if (take) begin
            valid <= !q_empty;
            if (!q_empty) word <= q_head;
        end
    end
endmodule

// File: rtl/fetch_front.sv
// Prefetch front end: issues sequential code fetches, tags each returned
// word with its fault, queues up to DEPTH words ahead of execute, and on
// a redirect drops the queue and the read in flight. Data requests from
// execute take the memory port for their cycle.
// Assumes the memory port answers every request in the next cycle.
module fetch_front
    import fe_pkg::*;
#(
    parameter int            DEPTH    = 2,
    parameter logic [AW-1:0] RESET_PC = 32'h0000_0000,
    parameter logic [AW-1:0] IO_BASE  = 32'hF000_0000,
    parameter logic [AW-1:0] IO_MASK  = 32'hF000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_code,
    output logic [AW-1:0] mem_addr,
    input  logic [IW-1:0] mem_rdata,
    input  logic          mem_err,
    input  logic          dat_req,
    input  logic [AW-1:0] dat_addr,
    input  logic          ex_done,
    input  logic          ex_redirect,
    input  logic [AW-1:0] ex_target,
    output logic          ex_valid,
    output logic [AW-1:0] ex_pc,
    output logic [IW-1:0] ex_instr,
    output logic          ex_fault
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic [AW-1:0] fetch_pc;
    logic [AW-1:0] fetch_sel;
    logic          io_hit;
    logic          issue;
    int            ahead;

    logic          inf_valid;
    logic [AW-1:0] inf_pc;
    logic          inf_guard;

    logic          q_push;
    fe_word_t      q_in;
    fe_word_t      q_head;
    logic          q_empty;
    logic [CW-1:0] q_count;
    logic          q_pop;
    fe_word_t      ex_word;

    // Next fetch address: aligned redirect target or sequential pointer
    always_comb begin
        fetch_sel = ex_redirect ? {ex_target[AW-1:2], 2'b00} : fetch_pc;
    end

    fe_io_guard #(
        .AW  (AW),
        .BASE(IO_BASE),
        .MASK(IO_MASK)
    ) u_guard (
        .addr(fetch_sel),
        .hit (io_hit)
    );

    // Credit check: words queued next cycle plus the new read stay within DEPTH
    always_comb begin
        if (ex_redirect) ahead = 0;
        else ahead = int'(q_count) - int'(q_pop) + int'(inf_valid);
        issue = !dat_req && (ahead < DEPTH);
    end

    // Memory port drive, data first, guarded fetches suppressed
    always_comb begin
        mem_req  = dat_req || (issue && !io_hit);
        mem_code = !dat_req;
        mem_addr = dat_req ? dat_addr : fetch_sel;
    end

    // Fetch pointer and in-flight record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc  <= RESET_PC;
            inf_valid <= 1'b0;
            inf_pc    <= '0;
            inf_guard <= 1'b0;
        end else begin
            fetch_pc  <= issue ? fetch_sel + STEP : fetch_sel;
            inf_valid <= issue;
            inf_pc    <= fetch_sel;
            inf_guard <= io_hit;
        end
    end

    // Returning word with its fault tag, dropped if a redirect is taken now
    always_comb begin
        q_push      = inf_valid && !ex_redirect;
        q_in.pc     = inf_pc;
        q_in.instr  = inf_guard ? '0 : mem_rdata;
        q_in.fault  = inf_guard || mem_err;
    end

    fe_word_fifo #(
        .DEPTH(DEPTH)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ex_redirect),
        .push     (q_push),
        .push_word(q_in),
        .pop      (q_pop),
        .head     (q_head),
        .empty    (q_empty),
        .count    (q_count)
    );

    fe_exec_stage u_exec (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (ex_redirect),
        .done   (ex_done),
        .q_empty(q_empty),
        .q_head (q_head),
        .pop    (q_pop),
        .valid  (ex_valid),
        .word   (ex_word)
    );

    // Execute-side outputs; fault only shown with a valid word
    always_comb begin
        ex_pc    = ex_word.pc;
        ex_instr = ex_word.instr;
        ex_fault = ex_valid && ex_word.fault;
    end
endmodule

// File: rtl/fe_checker.sv
// Property checker for fetch_front, attached with bind.
// Assumes ex_done/ex_redirect only with ex_valid, and redirect with done.
module fe_checker #(
    parameter int            AW      = 32,
    parameter logic [AW-1:0] IO_BASE = 32'hF000_0000,
    parameter logic [AW-1:0] IO_MASK = 32'hF000_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_code,
    input logic [AW-1:0] mem_addr,
    input logic          dat_req,
    input logic [AW-1:0] dat_addr,
    input logic          ex_done,
    input logic          ex_redirect,
    input logic          ex_valid,
    input logic [AW-1:0] ex_pc,
    input logic [31:0]   ex_instr,
    input logic          ex_fault
);
    AST_NO_IO_CODE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_code) |-> ((mem_addr & IO_MASK) != (IO_BASE & IO_MASK))); // R9

    AST_DATA_TAKES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        dat_req |-> (mem_req && !mem_code && (mem_addr == dat_addr))); // R8

    AST_REDIRECT_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ex_redirect |=> !ex_valid); // R4

    AST_REDIRECT_GAP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ex_redirect) |=> !ex_valid); // R4

    AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ex_fault |-> ex_valid); // R6

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_done && !ex_redirect) |=>
            (ex_valid && $stable(ex_pc) && $stable(ex_instr))); // R3

    AST_SEQUENTIAL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_done && !ex_redirect) |=>
            (!ex_valid || (ex_pc == $past(ex_pc) + AW'(4)))); // R11
endmodule

bind fetch_front fe_checker #(
    .AW     (32),
    .IO_BASE(IO_BASE),
    .IO_MASK(IO_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_code   (mem_code),
    .mem_addr   (mem_addr),
    .dat_req    (dat_req),
    .dat_addr   (dat_addr),
    .ex_done    (ex_done),
    .ex_redirect(ex_redirect),
    .ex_valid   (ex_valid),
    .ex_pc      (ex_pc),
    .ex_instr   (ex_instr),
    .ex_fault   (ex_fault)
);

// File: tb/sim_fetch_front.sv
module sim_fetch_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_req, mem_code, mem_err;
    logic [31:0] mem_addr, mem_rdata;
    logic        dat_req;
    logic [31:0] dat_addr;
    logic        ex_done, ex_redirect;
    logic [31:0] ex_target;
    logic        ex_valid, ex_fault;
    logic [31:0] ex_pc, ex_instr;

    int checks = 0;
    int errors = 0;
    int io_leak = 0;
    bit finished = 0;

    localparam logic [31:0] MARK = 32'h5A5A_0000;

    always #4 clk = ~clk;

    fetch_front u0 (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_code(mem_code), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .dat_req(dat_req), .dat_addr(dat_addr),
        .ex_done(ex_done), .ex_redirect(ex_redirect), .ex_target(ex_target),
        .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr), .ex_fault(ex_fault)
    );

    // Memory model: one-cycle answer, faults at 0x100 and 0x104 code reads
    always_ff @(posedge clk) begin
        mem_rdata <= mem_addr ^ MARK;
        mem_err   <= mem_req && mem_code && (mem_addr == 32'h100 || mem_addr == 32'h104);
        if (mem_req && mem_code && mem_addr[31:28] == 4'hF) io_leak <= io_leak + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // {done, redirect, target, exp_valid, exp_pc, exp_fault}
    localparam int NV = 30;
    localparam logic [67:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b1, 1'b0, 32'h0,         1'b1, 32'h000,       1'b0},
        {1'b1, 1'b0, 32'h0,         1'b1, 32'h004,       1'b0},
        {1'b0, 1'b0, 32'h0,         1'b1, 32'h008,       1'b0},
        {1'b0, 1'b0, 32'h0,         1'b1, 32'h008,       1'b0},
        {1'b1, 1'b0, 32'h0,         1'b1, 32'h008,       1'b0},
        {1'b1, 1'b0, 32'h0,         1'b1, 32'h00C,       1'b0},
        {1'b1, 1'b1, 32'h0FB,       1'b1, 32'h010,       1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b1, 1'b0, 32'h0,         1'b1, 32'h0F8,       1'b0},
        {1'b1, 1'b1, 32'h200,       1'b1, 32'h0FC,       1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b1, 1'b0, 32'h0,         1'b1, 32'h200,       1'b0},
        {1'b1, 1'b0, 32'h0,         1'b1, 32'h204,       1'b0},
        {1'b1, 1'b1, 32'h103,       1'b1, 32'h208,       1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b1, 1'b0, 32'h0,         1'b1, 32'h100,       1'b1},
        {1'b1, 1'b0, 32'h0,         1'b1, 32'h104,       1'b1},
        {1'b1, 1'b1, 32'hF000_0002, 1'b1, 32'h108,       1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b1, 1'b1, 32'h040,       1'b1, 32'hF000_0000, 1'b1},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         1'b0},
        {1'b0, 1'b0, 32'h0,         1'b1, 32'h040,       1'b0}
    };

    // Requirement tag for each table step
    function automatic string tag_of(input int i);
        if (i < 3)  return "R1";
        if (i < 5)  return "R2";
        if (i < 8)  return "R3";
        if (i < 9)  return "R11";
        if (i < 13) return "R4";
        if (i < 18) return "R7";
        if (i < 23) return "R6";
        return "R9";
    endfunction

    initial begin
        rst_n = 1'b0; dat_req = 1'b0; dat_addr = '0;
        ex_done = 1'b0; ex_redirect = 1'b0; ex_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state and first fetch
        chk(ex_valid == 1'b0, "R1", "ex_valid after reset", 32'(ex_valid), 32'h0);
        chk(mem_req && mem_code && mem_addr == 32'h0, "R1", "first fetch addr",
            mem_addr, 32'h0);
        rst_n = 1'b1;
        #1;
        chk(mem_req && mem_code && mem_addr == 32'h0, "R1", "first fetch after release",
            mem_addr, 32'h0);

        // Table walk: check state at the falling edge, then drive this cycle
        for (int i = 0; i < NV; i++) begin
            logic        v_done, v_redir, v_ev, v_ef;
            logic [31:0] v_tgt, v_pc;
            {v_done, v_redir, v_tgt, v_ev, v_pc, v_ef} = VEC[i];
            if (i > 0) @(negedge clk);
            chk(ex_valid == v_ev, tag_of(i), $sformatf("step %0d ex_valid", i),
                32'(ex_valid), 32'(v_ev));
            if (v_ev) begin
                chk(ex_pc == v_pc, tag_of(i), $sformatf("step %0d ex_pc", i), ex_pc, v_pc);
                chk(ex_fault == v_ef, tag_of(i), $sformatf("step %0d ex_fault", i),
                    32'(ex_fault), 32'(v_ef));
                if (!v_ef)
                    chk(ex_instr == (v_pc ^ MARK), tag_of(i),
                        $sformatf("step %0d ex_instr", i), ex_instr, v_pc ^ MARK);
            end else begin
                chk(ex_fault == 1'b0, tag_of(i), $sformatf("step %0d ex_fault idle", i),
                    32'(ex_fault), 32'h0);
            end
            ex_done = v_done; ex_redirect = v_redir; ex_target = v_tgt;
            #1;
            if (v_redir) begin
                if (v_tgt[31:28] == 4'hF)
                    chk(mem_req == 1'b0, "R9", "guarded fetch on bus", 32'(mem_req), 32'h0);
                else
                    chk(mem_req && mem_code && mem_addr == {v_tgt[31:2], 2'b00}, "R5",
                        "redirect fetch address", mem_addr, {v_tgt[31:2], 2'b00});
            end
        end

        // Directed: data accesses interleaved with steady fetch (R8, R10, R2)
        begin
            logic [31:0] expn = 32'h40;
            int seen = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (ex_valid) begin
                    chk(ex_pc == expn && !ex_fault, "R2", "sequential pc with data traffic",
                        ex_pc, expn);
                    expn += 32'd4;
                    seen++;
                end
                ex_done = 1'b1; ex_redirect = 1'b0;
                dat_req = (c % 4 == 1);
                dat_addr = (c % 8 == 1) ? 32'hF000_0010 : 32'h0000_0300;
                #1;
                if (dat_req)
                    chk(mem_req && !mem_code && mem_addr == dat_addr,
                        (dat_addr[31:28] == 4'hF) ? "R10" : "R8", "data access on port",
                        mem_addr, dat_addr);
            end
            chk(seen >= 25, "R2", "words delivered", 32'(seen), 32'd25);
            dat_req = 1'b0; ex_done = 1'b0;
        end

        // Directed: reset in mid-run, then a long stall (R1, R3)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ex_valid == 1'b0, "R1", "ex_valid in reset", 32'(ex_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(ex_valid == 1'b0, "R1", "ex_valid second cycle after reset", 32'(ex_valid), 32'h0);
        @(negedge clk);
        chk(ex_valid && ex_pc == 32'h0, "R1", "first word in execute", ex_pc, 32'h0);
        ex_done = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(mem_req == 1'b0, "R3", "no fetch while two words ahead", 32'(mem_req), 32'h0);
        chk(ex_valid && ex_pc == 32'h0, "R3", "stalled word held", ex_pc, 32'h0);
        for (int k = 1; k <= 4; k++) begin
            ex_done = 1'b1;
            @(negedge clk);
            chk(ex_valid && ex_pc == 32'(4 * k), "R3", "resume order", ex_pc, 32'(4 * k));
        end
        ex_done = 1'b0;

        chk(io_leak == 0, "R9", "code fetches seen in I/O window", 32'(io_leak), 32'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule